// File: doc/BRIEF.md
# Rotate-Then-Mask Execution Unit

This unit carries out the rotate-left-then-mask family of integer operations for both 32-bit word forms and 64-bit doubleword forms. One operand is rotated left by an amount taken either from an immediate field or from the low bits of a register. A contiguous mask is then applied. The mask may wrap around, and its bits are numbered big-endian, so bit 0 is the most significant bit. Depending on the operation, the unit either clears every bit outside the mask or inserts the masked rotated bits into the current destination value.

The caller passes in the raw instruction fields: a 5-bit rotate field, 5-bit begin and end fields, the two split high-order bits used by the doubleword immediate forms, and a 2-bit subtype. Operand fetch, carry-out shifts and condition recording stay outside the block. The result is registered. An operation strobe on `valid_i` produces `valid_o` one cycle later. Unsupported codes raise `illegal_o` and leave the result unchanged.

Top module: `rotmask_unit`

## Requirements
- R1: For word forms (`op_i` 0, 1, 2), the low 32 bits of `src_i` are placed in both halves of a 64-bit value, and that value is rotated left as a whole 64-bit quantity.
- R2: The mask holds ones from big-endian index `b` through index `e`, where index 0 is bit 63. When `e < b` the mask wraps and holds ones at `b..63` and at `0..e`. Word forms use `b = mb_fld_i + 32` and `e = me_fld_i + 32`, so a wrapped word mask also sets the whole upper half.
- R3: Insert forms (`op_i` 0, and `op_i` 3 with subtype 3) produce `(dst_i & ~mask) | (rot & mask)`. All other legal forms produce `rot & mask`.
- R4: A rotate amount of 0 passes the operand through unrotated.
- R5: The word register-amount form (`op_i` 2) rotates by `rs_amt_i[4:0]`. It ignores `rs_amt_i[5]` and `rb_fld_i`.
- R6: The doubleword immediate form (`op_i` 3) builds its 6-bit mask index as `{mb_hi_i, mb_fld_i}` and its 6-bit rotate amount as `{sh_hi_i, rb_fld_i}`.
- R7: For `op_i` 3, with `mb` the 6-bit index and `sh` the 6-bit amount, the subtype selects the mask. Subtype 0 uses mask(mb,63). Subtype 1 uses mask(0,mb). Subtype 2 clears with mask(mb,63-sh). Subtype 3 inserts with mask(mb,63-sh).
- R8: The doubleword register-amount form (`op_i` 4) rotates by `rs_amt_i[5:0]` and takes its mask index from `{mb_hi_i, mb_fld_i}`. Subtype 0 uses mask(mb,63) and subtype 1 uses mask(0,mb). Subtypes 2 and 3 are illegal.
- R9: An illegal operation (`op_i` 5..7, or `op_i` 4 with subtype 2 or 3) sets `illegal_o` together with `valid_o` one cycle later and leaves `result_o` unchanged. A legal operation clears `illegal_o`.
- R10: `valid_o` follows `valid_i` with one cycle of latency. While `valid_o` is low, `result_o` holds its value.
- R11: Reset drives `valid_o`, `illegal_o` and `result_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation: 0 word insert imm, 1 word clear imm, 2 word clear reg, 3 dword imm, 4 dword reg |
| sub_i | input | 2 | Doubleword subtype |
| src_i | input | 64 | Operand to rotate |
| dst_i | input | 64 | Current destination value, used by insert forms |
| rs_amt_i | input | 6 | Low bits of the rotate-amount register |
| rb_fld_i | input | 5 | Immediate rotate field |
| mb_fld_i | input | 5 | Mask begin field |
| me_fld_i | input | 5 | Mask end field (word forms) |
| mb_hi_i | input | 1 | High bit of the doubleword mask index |
| sh_hi_i | input | 1 | High bit of the doubleword immediate rotate |
| valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Operation was unsupported |
| result_o | output | 64 | Registered result |

## Verification
The hardest behaviour to reach from the ports is a wrapped word mask. With the end index below the begin index, the mask reaches into the upper 32 bits, and the replicated copy of the word becomes visible there. The stimulus uses begin/end pairs such as 24/7 and 31/0 on an operand whose upper input half differs from its low word, so both the wrap and the replication show up. Holding the result across an illegal operation is checked by first loading a known result and then issuing illegal codes back to back.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int RM_XLEN = 64;
  localparam int RM_IDXW = $clog2(RM_XLEN);

  typedef enum logic [2:0] {
    OP_WINS_IMM = 3'd0,
    OP_WCLR_IMM = 3'd1,
    OP_WCLR_REG = 3'd2,
    OP_DIMM     = 3'd3,
    OP_DREG     = 3'd4
  } rm_op_e;

  typedef struct packed {
    logic [RM_IDXW-1:0] rot;
    logic [RM_IDXW-1:0] mbeg;
    logic [RM_IDXW-1:0] mend;
    logic               ins;
    logic               word;
    logic               bad;
  } rm_ctl_t;
endpackage

// File: rtl/rm_decode.sv
module rm_decode
  import rotmask_pkg::*;
(
  input  logic [2:0]         op_i,
  input  logic [1:0]         sub_i,
  input  logic [RM_IDXW-1:0] rs_amt_i,
  input  logic [4:0]         rb_fld_i,
  input  logic [4:0]         mb_fld_i,
  input  logic [4:0]         me_fld_i,
  input  logic               mb_hi_i,
  input  logic               sh_hi_i,
  output rm_ctl_t            ctl_o
);
  localparam logic [RM_IDXW-1:0] LAST = RM_IDXW'(RM_XLEN - 1);

  logic [RM_IDXW-1:0] mb6, sh6, rsh6;

  assign mb6  = {mb_hi_i, mb_fld_i};
  assign sh6  = {sh_hi_i, rb_fld_i};
  assign rsh6 = rs_amt_i;

  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_WINS_IMM, OP_WCLR_IMM, OP_WCLR_REG: begin
        ctl_o.word = 1'b1;
        ctl_o.ins  = (op_i == OP_WINS_IMM);
        ctl_o.rot  = (op_i == OP_WCLR_REG) ? {1'b0, rsh6[4:0]} : {1'b0, rb_fld_i};
        // word indices sit in the low half of big-endian numbering
        ctl_o.mbeg = {1'b1, mb_fld_i};
        ctl_o.mend = {1'b1, me_fld_i};
      end
      OP_DIMM: begin
        ctl_o.rot = sh6;
        unique case (sub_i)
          2'd0: begin ctl_o.mbeg = mb6;  ctl_o.mend = LAST; end
          2'd1: begin ctl_o.mbeg = '0;   ctl_o.mend = mb6;  end
          default: begin
            ctl_o.mbeg = mb6;
            ctl_o.mend = LAST - sh6;
            ctl_o.ins  = (sub_i == 2'd3);
          end
        endcase
      end
      OP_DREG: begin
        ctl_o.rot = rsh6;
        unique case (sub_i)
          2'd0:    begin ctl_o.mbeg = mb6; ctl_o.mend = LAST; end
          2'd1:    begin ctl_o.mbeg = '0;  ctl_o.mend = mb6;  end
          default: ctl_o.bad = 1'b1;
        endcase
      end
      default: ctl_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  // W is a power of two, so index arithmetic wraps naturally
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [AW-1:0] src_idx;
    assign src_idx   = AW'(i) - amt_i;
    assign data_o[i] = data_i[src_idx];
  end
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] beg_i,
  input  logic [AW-1:0] end_i,
  output logic [W-1:0]  mask_o
);
  logic wrap;
  assign wrap = end_i < beg_i;

  // index k is big-endian: k = 0 is the MSB
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic ge_beg, le_end;
    assign ge_beg = AW'(k) >= beg_i;
    assign le_end = AW'(k) <= end_i;
    assign mask_o[W-1-k] = wrap ? (ge_beg | le_end) : (ge_beg & le_end);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int XLEN = RM_XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [1:0]      sub_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [5:0]      rs_amt_i,
  input  logic [4:0]      rb_fld_i,
  input  logic [4:0]      mb_fld_i,
  input  logic [4:0]      me_fld_i,
  input  logic            mb_hi_i,
  input  logic            sh_hi_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  localparam int WL = XLEN / 2;
  localparam int AW = $clog2(XLEN);

  rm_ctl_t         ctl;
  logic [XLEN-1:0] opnd, rot, mask, nxt;
  logic            valid_q, bad_q;
  logic [XLEN-1:0] res_q;

  rm_decode u_dec (
    .op_i     (op_i),
    .sub_i    (sub_i),
    .rs_amt_i (rs_amt_i),
    .rb_fld_i (rb_fld_i),
    .mb_fld_i (mb_fld_i),
    .me_fld_i (me_fld_i),
    .mb_hi_i  (mb_hi_i),
    .sh_hi_i  (sh_hi_i),
    .ctl_o    (ctl)
  );

  assign opnd = ctl.word ? {src_i[WL-1:0], src_i[WL-1:0]} : src_i;

  rm_rotator #(.W(XLEN), .AW(AW)) u_rot (
    .data_i (opnd),
    .amt_i  (ctl.rot),
    .data_o (rot)
  );

  rm_mask_gen #(.W(XLEN), .AW(AW)) u_mask (
    .beg_i  (ctl.mbeg),
    .end_i  (ctl.mend),
    .mask_o (mask)
  );

  assign nxt = ctl.ins ? ((dst_i & ~mask) | (rot & mask)) : (rot & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bad_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      bad_q   <= valid_i & ctl.bad;
      if (valid_i && !ctl.bad) res_q <= nxt;
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = bad_q;
  assign result_o  = res_q;
endmodule

// File: rtl/rotmask_chk.sv
module rotmask_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic [1:0]      sub_i,
  input logic            valid_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] result_o
);
  assert_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  assert_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && $stable(result_o)));

  assert_dreg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && sub_i[1]) |=> illegal_o);

  assert_badop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> illegal_o);

  assert_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4 && !(op_i == 3'd4 && sub_i[1])) |=> !illegal_o);
endmodule

bind rotmask_unit rotmask_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .sub_i     (sub_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SRC = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sub;
    logic [63:0] dst;
    logic [5:0]  amt;
    logic [4:0]  rb;
    logic [4:0]  mb;
    logic [4:0]  me;
    logic        mbh;
    logic        shh;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 2'd0, 64'h0, 6'h00, 5'd0,  5'd0,  5'd31, 1'b0, 1'b0, 64'h0000_0000_89AB_CDEF, 8'd4}, // R4 R1
    '{3'd1, 2'd0, 64'h0, 6'h00, 5'd8,  5'd0,  5'd31, 1'b0, 1'b0, 64'h0000_0000_ABCD_EF89, 8'd1}, // R1
    '{3'd1, 2'd0, 64'h0, 6'h00, 5'd0,  5'd24, 5'd7,  1'b0, 1'b0, 64'h89AB_CDEF_8900_00EF, 8'd2}, // R2 wrap
    '{3'd0, 2'd0, 64'h1111_2222_3333_4444, 6'h00, 5'd4, 5'd8, 5'd15, 1'b0, 1'b0,
      64'h1111_2222_33BC_4444, 8'd3},                                                         // R3
    '{3'd2, 2'd0, 64'h0, 6'h28, 5'd0,  5'd0,  5'd31, 1'b0, 1'b0, 64'h0000_0000_ABCD_EF89, 8'd5}, // R5
    '{3'd3, 2'd0, 64'h0, 6'h00, 5'd4,  5'd0,  5'd0,  1'b1, 1'b0, 64'h0000_0000_9ABC_DEF0, 8'd6}, // R6
    '{3'd3, 2'd1, 64'h0, 6'h00, 5'd0,  5'd31, 5'd0,  1'b0, 1'b1, 64'h89AB_CDEF_0000_0000, 8'd6}, // R6
    '{3'd3, 2'd2, 64'h0, 6'h00, 5'd8,  5'd0,  5'd0,  1'b0, 1'b0, 64'h2345_6789_ABCD_EF00, 8'd7}, // R7
    '{3'd3, 2'd3, 64'h1111_2222_3333_4444, 6'h00, 5'd16, 5'd16, 5'd0, 1'b0, 1'b0,
      64'h1111_89AB_CDEF_4444, 8'd7},                                                         // R7 R3
    '{3'd4, 2'd0, 64'h0, 6'h04, 5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 64'h0000_0000_9ABC_DEF0, 8'd8}, // R8
    '{3'd4, 2'd1, 64'h0, 6'h00, 5'd0,  5'd7,  5'd0,  1'b0, 1'b0, 64'h0100_0000_0000_0000, 8'd8}, // R8 R4
    '{3'd3, 2'd0, 64'h0, 6'h00, 5'd31, 5'd0,  5'd0,  1'b0, 1'b1, 64'h8091_A2B3_C4D5_E6F7, 8'd6}, // R6 sh=63
    '{3'd2, 2'd0, 64'h0, 6'h00, 5'd0,  5'd31, 5'd0,  1'b0, 1'b0, 64'h89AB_CDEF_8000_0001, 8'd2}  // R2 wrap
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  sub_i = '0;
  logic [63:0] src_i = SRC;
  logic [63:0] dst_i = '0;
  logic [5:0]  rs_amt_i = '0;
  logic [4:0]  rb_fld_i = '0, mb_fld_i = '0, me_fld_i = '0;
  logic        mb_hi_i = 1'b0, sh_hi_i = 1'b0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmask_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .sub_i(sub_i),
    .src_i(src_i), .dst_i(dst_i), .rs_amt_i(rs_amt_i), .rb_fld_i(rb_fld_i),
    .mb_fld_i(mb_fld_i), .me_fld_i(me_fld_i), .mb_hi_i(mb_hi_i), .sh_hi_i(sh_hi_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one strobe; returns at the negedge after the capturing edge
  task automatic issue(input vec_t v);
    @(negedge clk);
    op_i = v.op; sub_i = v.sub; dst_i = v.dst; rs_amt_i = v.amt;
    rb_fld_i = v.rb; mb_fld_i = v.mb; me_fld_i = v.me;
    mb_hi_i = v.mbh; sh_hi_i = v.shh; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t v;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk("R11 valid_o in reset", {63'd0, valid_o}, 64'd0);
    chk("R11 illegal_o in reset", {63'd0, illegal_o}, 64'd0);
    chk("R11 result_o in reset", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i]);
      total++;
      if (result_o !== TBL[i].exp || valid_o !== 1'b1 || illegal_o !== 1'b0) begin
        bad++;
        $display("FAIL R%0d row %0d act=%h v=%b il=%b exp=%h", TBL[i].req, i,
                 result_o, valid_o, illegal_o, TBL[i].exp);
      end
    end

    // R10: strobe drops after one cycle, result held while idle
    held = result_o;
    @(negedge clk);
    chk("R10 valid_o drops", {63'd0, valid_o}, 64'd0);
    chk("R10 result held idle", result_o, held);

    // R4: zero rotate, full doubleword mask passes the operand through
    v = '{3'd3, 2'd0, 64'h0, 6'h00, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, SRC, 8'd4};
    issue(v);
    chk("R4 zero rotate dword", result_o, SRC);
    held = result_o;

    // R8 R9: register dword subtypes 2 and 3 are illegal, result kept
    for (int s = 2; s < 4; s++) begin
      v = '{3'd4, 2'(s), 64'hFFFF_FFFF_FFFF_FFFF, 6'h01, 5'd1, 5'd1, 5'd1, 1'b0, 1'b0, 64'h0, 8'd8};
      issue(v);
      chk("R8 dreg bad subtype illegal_o", {63'd0, illegal_o}, 64'd1);
      chk("R9 valid_o with illegal", {63'd0, valid_o}, 64'd1);
      chk("R9 result unchanged on illegal", result_o, held);
    end

    // R9: op codes 5..7 illegal
    for (int o = 5; o < 8; o++) begin
      v = '{3'(o), 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 6'h00, 5'd3, 5'd0, 5'd31, 1'b0, 1'b0, 64'h0, 8'd9};
      issue(v);
      chk("R9 unsupported op illegal_o", {63'd0, illegal_o}, 64'd1);
      chk("R9 result unchanged on bad op", result_o, held);
    end

    // R9: a legal op clears illegal_o; R5: rb field and amount bit5 ignored
    v = '{3'd2, 2'd0, 64'h0, 6'h20, 5'd13, 5'd0, 5'd31, 1'b0, 1'b0, 64'h0, 8'd5};
    issue(v);
    chk("R9 legal clears illegal_o", {63'd0, illegal_o}, 64'd0);
    chk("R5 reg word ignores rb and bit5", result_o, 64'h0000_0000_89AB_CDEF);

    finish_run();
  end
endmodule